// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the host write path of a byte-wide non-volatile store. It watches each host byte write (address and data) and recognises multi-cycle unlock commands. All commands share a two-byte prefix. The third byte either completes a short 3-byte command or leads into a 6-byte command. The decoder drives a write-protection flag, a page-load strobe for each accepted data byte, a single-cycle chip-erase start strobe and a product-identification mode flag. While that mode is active it also answers reads at two addresses with fixed identification bytes.

The protection flag sits in a register that only the power-on reset `por_n` touches. Power-on sets it. The functional reset `rst_n` returns the sequence tracker and the identification mode to idle, and the protection flag keeps its value. Storage, buffering and timing are outside the block. A downstream engine raises `op_done` for one cycle when programming or erasure has finished, and that pulse closes the open page window or the erase wait.

States: `ST_IDLE` (no sequence in progress), `ST_S1` (AAh seen), `ST_S2` (prefix complete), `ST_S3` (80h seen), `ST_S4` (second AAh seen), `ST_S5` (second 55h seen), `ST_PAGE` (page-load window open) and `ST_ERASE` (waiting for erase to finish).

Transitions:
- `ST_IDLE`→`ST_S1` on AAh@5555h.
- `ST_S1`→`ST_S2` on 55h@2AAAh.
- `ST_S2`→`ST_PAGE` on A0h@5555h, which also sets protection.
- `ST_S2`→`ST_S3` on 80h@5555h.
- `ST_S2`→`ST_IDLE` on F0h@5555h, which also leaves identification mode.
- `ST_S3`→`ST_S4` on AAh@5555h.
- `ST_S4`→`ST_S5` on 55h@2AAAh.
- `ST_S5`→`ST_IDLE` on 20h@5555h, which clears protection.
- `ST_S5`→`ST_IDLE` on 60h@5555h, which enters identification mode.
- `ST_S5`→`ST_ERASE` on 10h@5555h, which pulses the erase strobe.
- `ST_PAGE`→`ST_IDLE` and `ST_ERASE`→`ST_IDLE` on `op_done`.
- In `ST_S1` to `ST_S5`, any other write goes to `ST_S1` if it is AAh@5555h and to `ST_IDLE` otherwise.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After `por_n` is asserted, `prot_on` is 1. `rst_n` alone never changes `prot_on`.
- R2: The sequence AAh@5555h, 55h@2AAAh, A0h@5555h sets `prot_on` and opens a page window. In that window, every write raises `page_wr` for one cycle, in the cycle after the write. An `op_done` pulse closes the window.
- R3: With `prot_on`=1 and no page window open, a write that starts no command gives no `page_wr`.
- R4: The 6-byte sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clears `prot_on`.
- R5: With `prot_on`=0, a write in idle that is not AAh@5555h raises `page_wr` for one cycle, in the cycle after the write.
- R6: The same 6-byte form ending in 10h raises `erase_go` for exactly one cycle. After that, writes give no `page_wr` until `op_done`.
- R7: The 6-byte form ending in 60h sets `id_mode`. While `id_mode`=1, `id_sel` and `id_data` respond to `rd_addr` combinationally: 0 gives DAh, 1 gives C1h, and any other address gives `id_sel`=0 with `id_data`=00h.
- R8: The 3-byte form AAh@5555h, 55h@2AAAh, F0h@5555h clears `id_mode`.
- R9: Command addresses are matched on `wr_addr[14:0]` only. Bit 16 set to 1 still matches.
- R10: A write that does not fit the current step returns the decoder to idle. If that write is AAh@5555h, it counts as a new first step.
- R11: `rst_n` clears `id_mode` and discards a partly received sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset for the protection flag, active low |
| wr_en | input | 1 | Host byte write strobe, one cycle per byte |
| wr_addr | input | 17 | Host write address |
| wr_data | input | 8 | Host write data |
| op_done | input | 1 | Pulse from engine: programming or erase finished |
| rd_addr | input | 17 | Host read address |
| page_wr | output | 1 | Strobe: the previous write is a page-load byte |
| erase_go | output | 1 | Strobe: start chip erase |
| prot_on | output | 1 | Software write protection enabled |
| id_mode | output | 1 | Product identification mode active |
| id_sel | output | 1 | Read address is answered with an identification byte |
| id_data | output | 8 | Identification byte for `rd_addr` |

## Verification
The vector table drives each full command (enable, disable, erase, identification entry and exit) between ordinary data writes. As a result, every command shows up both in its own mode output and in whether the data byte after it raises `page_wr`. Address bit 16 is set on one command to show that the high bits are not compared. A prefix broken by a wrong data byte, followed by the tail of an enable command, tells a true abort apart from a tracker that only stalls. A doubled AAh in the middle of a sequence shows the restart rule. Directed steps then check the identification reads and show that `rst_n` leaves protection alone and drops a half-received prefix, while `por_n` restores protection.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;
    localparam logic [7:0]  CODE_FIRST   = 8'hAA;
    localparam logic [7:0]  CODE_SECOND  = 8'h55;
    localparam logic [7:0]  CODE_LOCK    = 8'hA0;
    localparam logic [7:0]  CODE_EXTEND  = 8'h80;
    localparam logic [7:0]  CODE_ID_EXIT = 8'hF0;
    localparam logic [7:0]  CODE_UNLOCK  = 8'h20;
    localparam logic [7:0]  CODE_ERASE   = 8'h10;
    localparam logic [7:0]  CODE_ID_ON   = 8'h60;
    localparam logic [14:0] ADDR_CMD     = 15'h5555;
    localparam logic [14:0] ADDR_ALT     = 15'h2AAA;
    localparam logic [7:0]  ID_MAKER     = 8'hDA;
    localparam logic [7:0]  ID_PART      = 8'hC1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_PAGE, ST_ERASE
    } seq_state_t;

    typedef struct packed {
        logic at_cmd;
        logic hit_first;
        logic hit_second;
    } match_t;
endpackage

// File: rtl/unlock_cmd_match.sv
module unlock_cmd_match
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CMP_W  = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output match_t            hit
);
    logic [CMP_W-1:0] low_addr;
    assign low_addr = addr[CMP_W-1:0];

    always_comb begin
        hit.at_cmd     = (low_addr == ADDR_CMD[CMP_W-1:0]);
        hit.hit_first  = hit.at_cmd && (data == CODE_FIRST);
        hit.hit_second = (low_addr == ADDR_ALT[CMP_W-1:0]) && (data == CODE_SECOND);
    end
endmodule

// File: rtl/unlock_id_rom.sv
module unlock_id_rom
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              id_sel,
    output logic [7:0]        id_data
);
    logic upper_zero;
    assign upper_zero = (rd_addr[ADDR_W-1:1] == '0);

    always_comb begin
        id_sel  = id_mode && upper_zero;
        id_data = 8'h00;
        if (id_sel) begin
            id_data = rd_addr[0] ? ID_PART : ID_MAKER;
        end
    end
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CMP_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              op_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              page_wr,
    output logic              erase_go,
    output logic              prot_on,
    output logic              id_mode,
    output logic              id_sel,
    output logic [7:0]        id_data
);
    seq_state_t state, nxt;
    match_t     hit;
    seq_state_t restart;
    logic       pg_n, er_n, prot_set, prot_clr, id_set, id_clr;

    unlock_cmd_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    unlock_id_rom #(.ADDR_W(ADDR_W)) u_id (
        .id_mode (id_mode),
        .rd_addr (rd_addr),
        .id_sel  (id_sel),
        .id_data (id_data)
    );

    assign restart = hit.hit_first ? ST_S1 : ST_IDLE;

    always_comb begin
        nxt      = state;
        pg_n     = 1'b0;
        er_n     = 1'b0;
        prot_set = 1'b0;
        prot_clr = 1'b0;
        id_set   = 1'b0;
        id_clr   = 1'b0;
        unique case (state)
            ST_IDLE: if (wr_en) begin
                if (hit.hit_first) nxt = ST_S1;
                else if (!prot_on) pg_n = 1'b1;
            end
            ST_S1: if (wr_en) nxt = hit.hit_second ? ST_S2 : restart;
            ST_S2: if (wr_en) begin
                if (hit.at_cmd && wr_data == CODE_LOCK) begin
                    prot_set = 1'b1;
                    nxt      = ST_PAGE;
                end else if (hit.at_cmd && wr_data == CODE_EXTEND) begin
                    nxt = ST_S3;
                end else if (hit.at_cmd && wr_data == CODE_ID_EXIT) begin
                    id_clr = 1'b1;
                    nxt    = ST_IDLE;
                end else begin
                    nxt = restart;
                end
            end
            ST_S3: if (wr_en) nxt = hit.hit_first ? ST_S4 : ST_IDLE;
            ST_S4: if (wr_en) nxt = hit.hit_second ? ST_S5 : restart;
            ST_S5: if (wr_en) begin
                if (hit.at_cmd && wr_data == CODE_UNLOCK) begin
                    prot_clr = 1'b1;
                    nxt      = ST_IDLE;
                end else if (hit.at_cmd && wr_data == CODE_ERASE) begin
                    er_n = 1'b1;
                    nxt  = ST_ERASE;
                end else if (hit.at_cmd && wr_data == CODE_ID_ON) begin
                    id_set = 1'b1;
                    nxt    = ST_IDLE;
                end else begin
                    nxt = restart;
                end
            end
            ST_PAGE: begin
                if (wr_en)   pg_n = 1'b1;
                if (op_done) nxt  = ST_IDLE;
            end
            ST_ERASE: if (op_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_wr  <= 1'b0;
            erase_go <= 1'b0;
            id_mode  <= 1'b0;
        end else begin
            page_wr  <= pg_n;
            erase_go <= er_n;
            if (id_set)      id_mode <= 1'b1;
            else if (id_clr) id_mode <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        prot_on <= 1'b1;
        else if (prot_set) prot_on <= 1'b1;
        else if (prot_clr) prot_on <= 1'b0;
    end

    a_r1_prot_only_by_write: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !$past(wr_en) |-> $stable(prot_on));
    a_r2_load_follows_write: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        page_wr |-> $past(wr_en));
    a_r6_erase_single: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        erase_go |=> !erase_go);
    a_r6_erase_blocks_load: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (state == ST_ERASE) |=> !page_wr);
    a_r7_sel_needs_mode: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        id_sel |-> id_mode);
    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !(page_wr && erase_go));
endmodule

// File: tb/unlock_seq_decoder_tb.sv
module unlock_seq_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n, por_n, wr_en, op_done;
    logic [16:0] wr_addr, rd_addr;
    logic [7:0]  wr_data;
    logic        page_wr, erase_go, prot_on, id_mode, id_sel;
    logic [7:0]  id_data;
    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    unlock_seq_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .op_done(op_done),
        .rd_addr(rd_addr), .page_wr(page_wr), .erase_go(erase_go),
        .prot_on(prot_on), .id_mode(id_mode), .id_sel(id_sel), .id_data(id_data)
    );

    // {wr, addr, data, done, exp page_wr, exp erase_go, exp prot_on, exp id_mode}
    function automatic logic [30:0] vec(input logic w, input logic [16:0] a,
            input logic [7:0] d, input logic dn, input logic pg, input logic er,
            input logic pr, input logic id);
        return {w, a, d, dn, pg, er, pr, id};
    endfunction

    localparam int NV = 48;
    localparam logic [30:0] TABLE [NV] = '{
        vec(1, 17'h00010, 8'h12, 0, 0, 0, 1, 0), // R3 locked write dropped
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 1, 0),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 1, 0),
        vec(1, 17'h05555, 8'hA0, 0, 0, 0, 1, 0), // R2 window opens
        vec(1, 17'h00100, 8'h33, 0, 1, 0, 1, 0),
        vec(1, 17'h00101, 8'h44, 0, 1, 0, 1, 0),
        vec(0, 17'h00000, 8'h00, 1, 0, 0, 1, 0), // R2 window closes
        vec(1, 17'h00200, 8'h55, 0, 0, 0, 1, 0), // R3
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 1, 0),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 1, 0),
        vec(1, 17'h05555, 8'h80, 0, 0, 0, 1, 0),
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 1, 0),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 1, 0),
        vec(1, 17'h05555, 8'h20, 0, 0, 0, 0, 0), // R4 unlocked
        vec(1, 17'h00300, 8'h77, 0, 1, 0, 0, 0), // R5 pass-through
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 0, 0),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 0),
        vec(1, 17'h05555, 8'h80, 0, 0, 0, 0, 0),
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 0, 0),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 0),
        vec(1, 17'h05555, 8'h10, 0, 0, 1, 0, 0), // R6 erase strobe
        vec(1, 17'h00301, 8'h11, 0, 0, 0, 0, 0), // R6 ignored while erasing
        vec(0, 17'h00000, 8'h00, 1, 0, 0, 0, 0),
        vec(1, 17'h00302, 8'h22, 0, 1, 0, 0, 0), // R5
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 0, 0),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 0),
        vec(1, 17'h05555, 8'h80, 0, 0, 0, 0, 0),
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 0, 0),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 0),
        vec(1, 17'h05555, 8'h60, 0, 0, 0, 0, 1), // R7 id entry
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 0, 1),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 0, 1),
        vec(1, 17'h05555, 8'hF0, 0, 0, 0, 0, 0), // R8 id exit
        vec(1, 17'h15555, 8'hAA, 0, 0, 0, 0, 0), // R9 high bit ignored
        vec(1, 17'h12AAA, 8'h55, 0, 0, 0, 0, 0),
        vec(1, 17'h15555, 8'hA0, 0, 0, 0, 1, 0),
        vec(0, 17'h00000, 8'h00, 1, 0, 0, 1, 0),
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 1, 0), // R10 abort
        vec(1, 17'h02AAA, 8'h56, 0, 0, 0, 1, 0),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 1, 0),
        vec(1, 17'h05555, 8'hA0, 0, 0, 0, 1, 0),
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 1, 0), // R10 restart on AA
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 1, 0),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 1, 0),
        vec(1, 17'h05555, 8'h80, 0, 0, 0, 1, 0),
        vec(1, 17'h05555, 8'hAA, 0, 0, 0, 1, 0),
        vec(1, 17'h02AAA, 8'h55, 0, 0, 0, 1, 0),
        vec(1, 17'h05555, 8'h60, 0, 0, 0, 1, 1)
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [16:0] a, input logic [7:0] d,
                        input logic dn, output logic pg, output logic er);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; op_done = dn;
        @(negedge clk);
        pg = page_wr; er = erase_go;
        wr_en = 1'b0; op_done = 1'b0;
    endtask

    task automatic unlock_all();
        logic pg, er;
        step(1, 17'h05555, 8'hAA, 0, pg, er);
        step(1, 17'h02AAA, 8'h55, 0, pg, er);
        step(1, 17'h05555, 8'h80, 0, pg, er);
        step(1, 17'h05555, 8'hAA, 0, pg, er);
        step(1, 17'h02AAA, 8'h55, 0, pg, er);
        step(1, 17'h05555, 8'h20, 0, pg, er);
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic pg, er;
        rst_n = 1'b0; por_n = 1'b0; wr_en = 1'b0; op_done = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
        check("R1", "prot_on after por", prot_on, 1);
        check("R11", "id_mode after reset", id_mode, 0);
        check("R2", "page_wr after reset", page_wr, 0);

        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = TABLE[i];
            step(v[30], v[29:13], v[12:5], v[4], pg, er);
            check($sformatf("R2-5/R8-10 row%0d", i), "page_wr", pg, v[3]);
            check($sformatf("R6 row%0d", i), "erase_go", er, v[2]);
            check($sformatf("R1/R4 row%0d", i), "prot_on", prot_on, v[1]);
            check($sformatf("R7/R8 row%0d", i), "id_mode", id_mode, v[0]);
        end

        // R7 identification reads
        rd_addr = 17'h00000; #1;
        check("R7", "id_sel @0", id_sel, 1);
        check("R7", "id_data @0", id_data, 8'hDA);
        rd_addr = 17'h00001; #1;
        check("R7", "id_data @1", id_data, 8'hC1);
        rd_addr = 17'h00002; #1;
        check("R7", "id_sel @2", id_sel, 0);
        check("R7", "id_data @2", id_data, 8'h00);
        rd_addr = 17'h10000; #1;
        check("R7", "id_sel @10000", id_sel, 0);

        // R11 functional reset clears id mode, R1 keeps protection
        pulse_rst();
        check("R11", "id_mode after rst", id_mode, 0);
        check("R1", "prot_on kept (1) over rst", prot_on, 1);
        unlock_all();
        check("R4", "prot_on after unlock", prot_on, 0);
        pulse_rst();
        check("R1", "prot_on kept (0) over rst", prot_on, 0);

        // R11 partial prefix is discarded by reset
        step(1, 17'h05555, 8'hAA, 0, pg, er);
        step(1, 17'h02AAA, 8'h55, 0, pg, er);
        pulse_rst();
        step(1, 17'h05555, 8'hA0, 0, pg, er);
        check("R11", "prot_on after dropped prefix", prot_on, 0);
        check("R11", "page_wr for plain A0 write", pg, 1);

        // R1 power-on reset restores protection
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        check("R1", "prot_on after second por", prot_on, 1);
        step(1, 17'h00400, 8'h99, 0, pg, er);
        check("R3", "page_wr locked after por", pg, 0);

        finish_run();
    end
endmodule